// File: doc/BRIEF.md
# Register Rename Stage with Speculative and Committed Maps

This block sits between decode and scheduling in an out-of-order core. For every instruction it turns two architectural source register numbers into physical register numbers and gives the destination a physical register that nothing else is using. Because every write lands in a fresh physical register, later writers never disturb earlier readers or writers of the same architectural name.

Two mapping tables are kept. The speculative table is read and written at issue. The committed table changes only when an instruction retires, so only then does its destination become the architecturally visible copy. When an instruction retires, the physical register it replaced goes back on the free list. A flush discards all speculative state in one cycle. The speculative table is overwritten with the committed one, and the free list is rebuilt from every physical register the committed table does not reference.

Top module: `rename_unit`

## Requirements
- R1: After reset both tables map architectural register i to physical register i. The free list holds physical registers NUM_ARCH to NUM_PHYS-1 in ascending order, and `iss_ready` is high.
- R2: `iss_phys_a` and `iss_phys_b` show the speculative mapping of `iss_src_a` and `iss_src_b` combinationally. A destination renamed in the same cycle is not visible to that cycle's sources.
- R3: `iss_new_phys` is the head of the free list, and successive issues consume the free list in FIFO order. `iss_old_phys` is the speculative mapping of `iss_dst` before the issue.
- R4: On an issue (`iss_valid` and `iss_ready` both high at a clock edge), the speculative entry for `iss_dst` becomes `iss_new_phys` from the next cycle on.
- R5: `iss_ready` is low while the free list is empty. During that time `iss_valid` has no effect: no register is taken and the speculative table is unchanged.
- R6: On `cmt_valid`, the committed entry for `cmt_arch` becomes `cmt_new_phys`, and `cmt_old_phys` is appended to the tail of the free list.
- R7: On `flush`, the speculative table takes the committed table's contents, including a commit presented in the same cycle. `iss_ready` is low during the flush cycle.
- R8: After a flush, the free list holds exactly the physical registers not referenced by the committed table, in ascending order. A register freed by a same-cycle commit is included in that set rather than appended a second time.
- R9: An issue and a commit in the same cycle both take effect: one register leaves the head of the free list and one joins its tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for renaming |
| iss_src_a | input | $clog2(NUM_ARCH) | First architectural source |
| iss_src_b | input | $clog2(NUM_ARCH) | Second architectural source |
| iss_dst | input | $clog2(NUM_ARCH) | Architectural destination |
| iss_ready | output | 1 | A free register exists and no flush is in progress |
| iss_phys_a | output | $clog2(NUM_PHYS) | Physical register for the first source |
| iss_phys_b | output | $clog2(NUM_PHYS) | Physical register for the second source |
| iss_new_phys | output | $clog2(NUM_PHYS) | Physical register allocated to the destination |
| iss_old_phys | output | $clog2(NUM_PHYS) | Prior speculative mapping of the destination |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_arch | input | $clog2(NUM_ARCH) | Architectural destination of the retiring instruction |
| cmt_new_phys | input | $clog2(NUM_PHYS) | Physical register it was given at issue |
| cmt_old_phys | input | $clog2(NUM_PHYS) | Physical register it replaced, to be freed |
| flush | input | 1 | Discard all speculative renames |

## Verification
The bench builds the unit with 8 architectural and 16 physical registers, so the free list holds only eight entries. Every fill runs the list dry in eight issues, which puts the empty-list stall and the blocked issue attempts in reach many times over. With these sizes the bench can also read back every table entry after each flush and drain the rebuilt list completely to check its ascending order. Several rounds with different destination patterns mix commits, simultaneous issue and commit, and flushes that carry a commit.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // Free-list update selected each cycle
  typedef enum logic [2:0] {
    FL_HOLD   = 3'd0,
    FL_POP    = 3'd1,
    FL_PUSH   = 3'd2,
    FL_SWAP   = 3'd3,
    FL_RELOAD = 3'd4
  } fl_action_e;

  function automatic fl_action_e fl_decide(logic reload, logic push, logic pop);
    if (reload)           return FL_RELOAD;
    else if (push && pop) return FL_SWAP;
    else if (push)        return FL_PUSH;
    else if (pop)         return FL_POP;
    else                  return FL_HOLD;
  endfunction
endpackage

// File: rtl/rr_map.sv
module rr_map #(
  parameter int N = 16,
  parameter int W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [W-1:0]        wr_val,
  input  logic                load_en,
  input  logic [N-1:0][W-1:0] load_val,
  output logic [N-1:0][W-1:0] map_o
);
  logic [N-1:0][W-1:0] map_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) map_q[i] <= W'(i);
    end else if (load_en) begin
      map_q <= load_val;
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_val;
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/rr_free_scan.sv
module rr_free_scan #(
  parameter int NARCH = 16,
  parameter int NPHYS = 48,
  parameter int W     = 6,
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic [NARCH-1:0][W-1:0] map_i,
  output logic [DEPTH-1:0][W-1:0] list_o,
  output logic [CW-1:0]           cnt_o
);
  logic [NPHYS-1:0] used;
  int k;

  always_comb begin
    used = '0;
    for (int a = 0; a < NARCH; a++) begin
      for (int p = 0; p < NPHYS; p++) begin
        if (map_i[a] == W'(p)) used[p] = 1'b1;
      end
    end
    list_o = '0;
    k = 0;
    for (int p = 0; p < NPHYS; p++) begin
      if (!used[p]) begin
        if (k < DEPTH) list_o[k] = W'(p);
        k = k + 1;
      end
    end
    cnt_o = (k > DEPTH) ? CW'(DEPTH) : CW'(k);
  end
endmodule

// File: rtl/rr_free_fifo.sv
module rr_free_fifo
  import rr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 6,
  parameter int FIRST = 16,
  parameter int CW    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [W-1:0]            push_val,
  input  logic                    pop,
  input  logic                    reload,
  input  logic [DEPTH-1:0][W-1:0] reload_list,
  input  logic [CW-1:0]           reload_cnt,
  output logic [W-1:0]            head_val,
  output logic                    empty
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    slot_q [DEPTH];
  logic [PTRW-1:0] head_q, tail_q;
  logic [CW-1:0]   cnt_q;
  fl_action_e      act;

  function automatic logic [PTRW-1:0] ring_inc(logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTRW-1:0] tail_of(logic [CW-1:0] c);
    return (c >= CW'(DEPTH)) ? '0 : PTRW'(c);
  endfunction

  assign act = fl_decide(reload, push, pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= W'(FIRST + i);
      head_q <= '0;
      tail_q <= tail_of(CW'(DEPTH));
      cnt_q  <= CW'(DEPTH);
    end else begin
      case (act)
        FL_RELOAD: begin
          for (int i = 0; i < DEPTH; i++) slot_q[i] <= reload_list[i];
          head_q <= '0;
          tail_q <= tail_of(reload_cnt);
          cnt_q  <= reload_cnt;
        end
        FL_SWAP: begin
          slot_q[tail_q] <= push_val;
          tail_q <= ring_inc(tail_q);
          head_q <= ring_inc(head_q);
        end
        FL_PUSH: begin
          slot_q[tail_q] <= push_val;
          tail_q <= ring_inc(tail_q);
          cnt_q  <= cnt_q + 1'b1;
        end
        FL_POP: begin
          head_q <= ring_inc(head_q);
          cnt_q  <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign head_val = slot_q[head_q];
  assign empty    = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !reload) |-> (cnt_q != '0)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !reload) |-> (cnt_q < CW'(DEPTH))); // R6
  AST_RELOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(reload_cnt))); // R8
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_valid,
  input  logic [$clog2(NUM_ARCH)-1:0] iss_src_a,
  input  logic [$clog2(NUM_ARCH)-1:0] iss_src_b,
  input  logic [$clog2(NUM_ARCH)-1:0] iss_dst,
  output logic                        iss_ready,
  output logic [$clog2(NUM_PHYS)-1:0] iss_phys_a,
  output logic [$clog2(NUM_PHYS)-1:0] iss_phys_b,
  output logic [$clog2(NUM_PHYS)-1:0] iss_new_phys,
  output logic [$clog2(NUM_PHYS)-1:0] iss_old_phys,
  input  logic                        cmt_valid,
  input  logic [$clog2(NUM_ARCH)-1:0] cmt_arch,
  input  logic [$clog2(NUM_PHYS)-1:0] cmt_new_phys,
  input  logic [$clog2(NUM_PHYS)-1:0] cmt_old_phys,
  input  logic                        flush
);
  localparam int AW     = $clog2(NUM_ARCH);
  localparam int PW     = $clog2(NUM_PHYS);
  localparam int FREE_N = NUM_PHYS - NUM_ARCH;
  localparam int CW     = $clog2(FREE_N + 1);

  logic [NUM_ARCH-1:0][PW-1:0] spec_map, cmt_map, cmt_next;
  logic [FREE_N-1:0][PW-1:0]   rb_list;
  logic [CW-1:0]               rb_cnt;
  logic                        iss_fire, fl_push, fl_empty;
  logic [PW-1:0]               fl_head;

  // Committed table as it will stand after this cycle's retirement
  always_comb begin
    cmt_next = cmt_map;
    if (cmt_valid) cmt_next[cmt_arch] = cmt_new_phys;
  end

  assign iss_ready = !fl_empty && !flush;
  assign iss_fire  = iss_valid && iss_ready;
  assign fl_push   = cmt_valid && !flush;

  rr_map #(.N(NUM_ARCH), .W(PW)) spec_map_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(iss_fire), .wr_idx(iss_dst), .wr_val(fl_head),
    .load_en(flush), .load_val(cmt_next),
    .map_o(spec_map)
  );

  rr_map #(.N(NUM_ARCH), .W(PW)) cmt_map_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmt_valid), .wr_idx(cmt_arch), .wr_val(cmt_new_phys),
    .load_en(1'b0), .load_val('0),
    .map_o(cmt_map)
  );

  rr_free_scan #(.NARCH(NUM_ARCH), .NPHYS(NUM_PHYS), .W(PW), .DEPTH(FREE_N), .CW(CW)) scan_i (
    .map_i(cmt_next), .list_o(rb_list), .cnt_o(rb_cnt)
  );

  rr_free_fifo #(.DEPTH(FREE_N), .W(PW), .FIRST(NUM_ARCH), .CW(CW)) free_i (
    .clk(clk), .rst_n(rst_n),
    .push(fl_push), .push_val(cmt_old_phys),
    .pop(iss_fire),
    .reload(flush), .reload_list(rb_list), .reload_cnt(rb_cnt),
    .head_val(fl_head), .empty(fl_empty)
  );

  assign iss_phys_a   = spec_map[iss_src_a];
  assign iss_phys_b   = spec_map[iss_src_b];
  assign iss_old_phys = spec_map[iss_dst];
  assign iss_new_phys = fl_head;

  AST_ISSUE_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> (spec_map[$past(iss_dst)] == $past(fl_head))); // R4
  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_empty |-> !iss_fire); // R5
  AST_COMMIT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> (cmt_map[$past(cmt_arch)] == $past(cmt_new_phys))); // R6
  AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_map == cmt_map)); // R7
endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb_top;
  localparam int A  = 8;
  localparam int P  = 16;
  localparam int AW = 3;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0, cmt_valid = 1'b0, flush = 1'b0;
  logic [AW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0, cmt_arch = '0;
  logic [PW-1:0] cmt_new_phys = '0, cmt_old_phys = '0;
  logic iss_ready;
  logic [PW-1:0] iss_phys_a, iss_phys_b, iss_new_phys, iss_old_phys;

  int n_cmp = 0, n_bad = 0;
  int spec_m[A], cmt_m[A];
  int freeq[$];
  int pa[$], pn[$], po[$];

  always #5 clk = ~clk;

  rename_unit #(.NUM_ARCH(A), .NUM_PHYS(P)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .iss_ready(iss_ready), .iss_phys_a(iss_phys_a), .iss_phys_b(iss_phys_b),
    .iss_new_phys(iss_new_phys), .iss_old_phys(iss_old_phys),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_new_phys(cmt_new_phys),
    .cmt_old_phys(cmt_old_phys), .flush(flush)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Free list after a flush: every register absent from the committed table, ascending
  task automatic rebuild_model();
    freeq.delete();
    for (int p = 0; p < P; p++) begin
      bit hit = 0;
      for (int a = 0; a < A; a++) if (cmt_m[a] == p) hit = 1;
      if (!hit) freeq.push_back(p);
    end
  endtask

  task automatic step(string tag, bit v, int a, int b, int d, bit cv, bit fl);
    int exp_ready, newp, ca, cn, co;
    bit do_c;
    do_c = cv && (pa.size() != 0);
    @(negedge clk);
    iss_valid = v; iss_src_a = AW'(a); iss_src_b = AW'(b); iss_dst = AW'(d);
    flush = fl; cmt_valid = do_c;
    ca = 0; cn = 0; co = 0;
    if (do_c) begin
      ca = pa[0]; cn = pn[0]; co = po[0];
      cmt_arch = AW'(ca); cmt_new_phys = PW'(cn); cmt_old_phys = PW'(co);
    end
    #1;
    exp_ready = (freeq.size() != 0 && !fl) ? 1 : 0;
    check(tag, int'(iss_ready), exp_ready);
    check(tag, int'(iss_phys_a), spec_m[a]);
    check(tag, int'(iss_phys_b), spec_m[b]);
    check(tag, int'(iss_old_phys), spec_m[d]);
    if (freeq.size() != 0) check(tag, int'(iss_new_phys), freeq[0]);
    @(posedge clk);
    if (v && exp_ready != 0) begin
      newp = freeq.pop_front();
      pa.push_back(d); pn.push_back(newp); po.push_back(spec_m[d]);
      spec_m[d] = newp;
    end
    if (do_c) begin
      void'(pa.pop_front()); void'(pn.pop_front()); void'(po.pop_front());
      cmt_m[ca] = cn;
      if (!fl) freeq.push_back(co);
    end
    if (fl) begin
      for (int i = 0; i < A; i++) spec_m[i] = cmt_m[i];
      rebuild_model();
      pa.delete(); pn.delete(); po.delete();
    end
  endtask

  // Read every speculative entry without issuing
  task automatic sweep(string tag);
    for (int i = 0; i < A; i++) step(tag, 0, i, A - 1 - i, i, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < A; i++) begin spec_m[i] = i; cmt_m[i] = i; end
    for (int p = A; p < P; p++) freeq.push_back(p);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: identity tables and preloaded ascending free list
    sweep("R1");

    // R2: same-cycle destination not visible to sources; src equals dst
    step("R2", 1, 3, 3, 3, 0, 0);
    step("R2", 1, 3, 5, 5, 0, 0);
    step("R3", 1, 5, 3, 0, 0, 0);
    step("R4", 0, 0, 5, 3, 0, 0);
    sweep("R4");

    for (int r = 0; r < 3; r++) begin
      // R3: fill until the list runs dry, varied destinations
      for (int k = 0; k < P; k++) step("R3", 1, k % A, (k + 5) % A, (k * 3 + r) % A, 0, 0);
      // R5: attempts while empty change nothing
      for (int k = 0; k < 3; k++) step("R5", 1, k, k + 1, k + 2, 0, 0);
      sweep("R5");
      // R6: retire three, freed registers come back in order
      for (int k = 0; k < 3; k++) step("R6", 0, k, k, k, 1, 0);
      // R9: issue and retire together
      for (int k = 0; k < 4; k++) step("R9", 1, k, 7 - k, (k + r) % A, 1, 0);
      sweep("R6");
      // R7: flush with a retirement in the same cycle
      step("R7", 1, 1, 2, 3, 1, 1);
      sweep("R7");
      // R8: drain the rebuilt list and confirm order and size
      for (int k = 0; k < P - A + 1; k++) step("R8", 1, k % A, 0, (k + 2 * r) % A, 0, 0);
      for (int k = 0; k < 2; k++) step("R6", 0, 0, 0, 0, 1, 0);
      step("R8", 0, 0, 0, 0, 0, 1);
      sweep("R8");
    end

    @(negedge clk);
    iss_valid = 0; cmt_valid = 0; flush = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule